// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer that joins two unrelated clock domains. Words are written on one clock and read on the other. Each pointer crosses to the other side as Gray code through a pair of flops. Five status outputs report the fill level: data available, space left, almost empty, half full and almost full. The almost-empty and almost-full thresholds are set by two offset inputs that must stay constant while the FIFO runs.

The mode is chosen by a pin that is sampled only while the active-low master reset is asserted. In the standard mode a word reaches the output only after a read request. In the fall-through mode the head word is presented on the output by itself. That output register adds one word of capacity, so every fill threshold moves up by one word.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is LOW, `fall_mode` is captured in each clock domain: LOW selects standard mode, HIGH selects fall-through mode. At reset the outputs are: standard mode `avail_flag`=0, `space_flag`=1; fall-through mode `avail_flag`=1, `space_flag`=0. In both modes `almost_empty`=0, `half_full_n`=1, `almost_full_n`=1 and `dout`=0.
- R2: A word on `din` is stored on a rising `wr_clk` edge when `wr_en_n` is LOW and the FIFO is not full. A write while full is dropped. Words leave in the order they were written.
- R3: Standard mode: each word, including the first, is delivered to `dout` one `rd_clk` edge after a read with `rd_en_n` LOW. Without a read, `dout` holds its value. `avail_flag` is HIGH while data is present. A read while empty changes nothing.
- R4: Fall-through mode: the first word written into an empty FIFO appears on `dout` after the third rising `rd_clk` edge following its write, with no read request. `avail_flag` goes LOW at the same time. While `rd_en_n` is HIGH, `dout` holds. `avail_flag` returns HIGH after the last word has been read.
- R5: Standard mode: `space_flag` goes LOW once D words are stored. Fall-through mode: `space_flag` goes HIGH once D+1 words are held. In both modes the first read from a full FIFO releases the flag after synchronization.
- R6: `almost_empty` is HIGH when at least n+1 words are held (standard) or n+2 words (fall-through). It is LOW at or below n or n+1 words respectively. n is `empty_ofs`.
- R7: `half_full_n` goes LOW when word D/2+1 is written (standard) or word D/2+2 (fall-through), counted with no reads.
- R8: `almost_full_n` goes LOW after D−m writes (standard) or D+1−m writes (fall-through), counted with no reads. m is `full_ofs`.
- R9: Each Gray-coded pointer changes by at most one bit per clock of its own domain, so words cross between unrelated clocks intact.
- R10: Changing `fall_mode` after reset has no effect on flag polarity, output timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| fall_mode | input | 1 | Mode select, sampled during reset |
| empty_ofs | input | AW | Almost-empty offset n |
| full_ofs | input | AW | Almost-full offset m |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| dout | output | DW | Read data register |
| avail_flag | output | 1 | Standard: HIGH when data present; fall-through: LOW when dout is valid |
| space_flag | output | 1 | Standard: LOW when full; fall-through: HIGH when full |
| almost_empty | output | 1 | HIGH above the almost-empty threshold |
| half_full_n | output | 1 | LOW above half capacity |
| almost_full_n | output | 1 | LOW at or above the almost-full threshold |

## Verification
Each mode is tried with the same three patterns. The first is a single word written into an empty FIFO, which separates the fall-through delivery on the third read edge from the standard mode's wait for a read. The second is an uninterrupted fill to capacity followed by surplus writes. It places each write-side flag transition on the exact write count and shows where the extra fall-through word sits. The third is a continuous drain with reads past empty, interrupted once after the first read. It checks the almost-empty threshold at every level, the release of the full indication, data order across clocks of different periods, and that a mode pin toggled mid-run is ignored.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          fall_mode,
  input  logic [AW-1:0] empty_ofs,
  input  logic [AW-1:0] full_ofs,
  input  logic          wr_en_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  output logic [DW-1:0] dout,
  output logic          avail_flag,
  output logic          space_flag,
  output logic          almost_empty,
  output logic          half_full_n,
  output logic          almost_full_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic wrst_a, wrst, rrst_a, rrst;
  always_ff @(posedge wr_clk or negedge mrst_n)
    if (!mrst_n) {wrst, wrst_a} <= 2'b00;
    else         {wrst, wrst_a} <= {wrst_a, 1'b1};
  always_ff @(posedge rd_clk or negedge mrst_n)
    if (!mrst_n) {rrst, rrst_a} <= 2'b00;
    else         {rrst, rrst_a} <= {rrst_a, 1'b1};

  logic fwft_w, fwft_r;
  always_ff @(posedge wr_clk) if (!wrst) fwft_w <= fall_mode;
  always_ff @(posedge rd_clk) if (!rrst) fwft_r <= fall_mode;

  // write domain
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic          full, hf, paf;
  wire           wr_ok    = !wr_en_n && !full;
  wire [PW-1:0]  wbin_nxt = wbin + PW'(wr_ok);
  wire [PW-1:0]  wcnt     = wbin_nxt - g2b(rq2);
  wire [CW-1:0]  wlvl     = {1'b0, wcnt};

  always_ff @(posedge wr_clk) if (wr_ok) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge wrst)
    if (!wrst) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      full <= 1'b0; hf <= 1'b0; paf <= 1'b0;
    end else begin
      {rq2, rq1} <= {rq1, rgray};
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      full  <= wlvl == CW'(DEPTH);
      hf    <= wlvl > CW'(DEPTH / 2);
      paf   <= wlvl >= CW'(DEPTH) - CW'(full_ofs);
    end

  assign space_flag    = fwft_w ? full : ~full;
  assign half_full_n   = ~hf;
  assign almost_full_n = ~paf;

  // read domain
  logic [PW-1:0] rbin, rgray, wq1, wq2;
  logic          has_data, ovalid, pae;
  wire [PW-1:0]  wq_bin    = g2b(wq2);
  wire           mem_avail = wq_bin != rbin;
  wire           rd_ok     = !rd_en_n && has_data;
  wire           load      = mem_avail && (!ovalid || !rd_en_n);
  wire           pop_mem   = fwft_r ? load : rd_ok;
  wire [PW-1:0]  rbin_nxt  = rbin + PW'(pop_mem);
  wire           ov_nxt    = fwft_r && (load || (ovalid && rd_en_n));
  wire [CW-1:0]  rlvl      = {1'b0, wq_bin - rbin_nxt} + CW'(ov_nxt);

  always_ff @(posedge rd_clk or negedge rrst)
    if (!rrst) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      has_data <= 1'b0; ovalid <= 1'b0; pae <= 1'b0; dout <= '0;
    end else begin
      {wq2, wq1} <= {wq1, wgray};
      rbin     <= rbin_nxt;
      rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
      ovalid   <= ov_nxt;
      has_data <= wq_bin != rbin_nxt;
      pae      <= rlvl > CW'(empty_ofs) + CW'(fwft_r);
      if (pop_mem) dout <= mem[rbin[AW-1:0]];
    end

  assign avail_flag   = fwft_r ? ~ovalid : has_data;
  assign almost_empty = pae;

  // R2
  full_block_chk: assert property (@(posedge wr_clk) disable iff (!wrst)
    full |=> $stable(wbin));
  // R9
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!wrst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R9
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rrst)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R3
  std_empty_chk: assert property (@(posedge rd_clk) disable iff (!rrst)
    (!fwft_r && !has_data) |=> $stable(rbin) && $stable(dout));
  // R4
  fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (!rrst)
    (fwft_r && ovalid && rd_en_n) |=> ovalid && $stable(dout));
  // R6
  pae_data_chk: assert property (@(posedge rd_clk) disable iff (!rrst)
    pae |-> (fwft_r ? ovalid : has_data));
  // R10
  mode_hold_chk: assert property (@(posedge rd_clk) disable iff (!rrst)
    $stable(fwft_r));
endmodule

// File: tb/dual_mode_fifo_test.sv
`timescale 1ns/1ps
module dual_mode_fifo_test;
  localparam int DW = 36, AW = 4, D = 16, NOFS = 3, MOFS = 2;

  logic wr_clk = 0, rd_clk = 0, mrst_n = 0, fall_mode = 0;
  logic wr_en_n = 1, rd_en_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic avail_flag, space_flag, almost_empty, half_full_n, almost_full_n;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model[$];
  logic [DW-1:0] val = 36'h0_5000_0001;

  always #5   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  dual_mode_fifo #(.DW(DW), .AW(AW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .fall_mode(fall_mode),
    .empty_ofs(AW'(NOFS)), .full_ofs(AW'(MOFS)), .wr_en_n(wr_en_n), .din(din),
    .rd_en_n(rd_en_n), .dout(dout), .avail_flag(avail_flag), .space_flag(space_flag),
    .almost_empty(almost_empty), .half_full_n(half_full_n), .almost_full_n(almost_full_n));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit fm);
    mrst_n = 0; fall_mode = fm; wr_en_n = 1; rd_en_n = 1;
    model.delete();
    repeat (5) @(negedge rd_clk);
    mrst_n = 1;
    repeat (10) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    chk("R1 avail", avail_flag, fm ? 1 : 0);
    chk("R1 space", space_flag, fm ? 0 : 1);
    chk("R1 almost_empty", almost_empty, 0);
    chk("R1 half_full_n", half_full_n, 1);
    chk("R1 almost_full_n", almost_full_n, 1);
    chk("R1 dout", dout, 0);
  endtask

  task automatic first_word;
    @(negedge wr_clk); din = val; wr_en_n = 0;
    @(posedge wr_clk); #1 wr_en_n = 1;
    model.push_back(val); val++;
    @(posedge rd_clk); @(posedge rd_clk); @(negedge rd_clk);
    chk("R4 not yet after 2 edges", avail_flag, 1);
    @(posedge rd_clk); @(negedge rd_clk);
    chk("R4 valid after 3 edges", avail_flag, 0);
    chk("R4 first word", dout, model[0]);
    repeat (20) @(negedge wr_clk);
  endtask

  task automatic fill(bit fm);
    int cap = D + int'(fm);
    int mem;
    @(negedge wr_clk); din = val; wr_en_n = 0;
    while (1) begin
      @(negedge wr_clk);
      model.push_back(din);
      mem = model.size() - int'(fm);
      chk("R7 half_full_n", half_full_n, (mem > D / 2) ? 0 : 1);
      chk("R8 almost_full_n", almost_full_n, (mem >= D - MOFS) ? 0 : 1);
      chk("R5 space at fill", space_flag, (mem == D) ? (fm ? 1 : 0) : (fm ? 0 : 1));
      if (model.size() == cap) break;
      val++; din = val;
    end
    for (int i = 0; i < 3; i++) begin
      din = val + 36'd100 + DW'(i);
      @(negedge wr_clk);
      chk("R2 write while full ignored, flag", space_flag, fm ? 1 : 0);
    end
    wr_en_n = 1; val++;
    repeat (20) @(negedge rd_clk);
    chk("R6 almost_empty when full", almost_empty, 1);
    if (!fm) chk("R3 no read no output", dout, 0);
  endtask

  task automatic drain(bit fm);
    logic [DW-1:0] expv = '0;
    bit pend = 0, paused = 0;
    int extras = 0;
    fall_mode = ~fm;
    while (extras < 4) begin
      @(negedge rd_clk);
      if (fm) begin
        chk("R4/R10 avail", avail_flag, (model.size() > 0) ? 0 : 1);
        if (model.size() > 0) chk("R2/R9 data order", dout, model[0]);
        else chk("R4 dout held when empty", dout, expv);
        chk("R6 almost_empty", almost_empty, (model.size() >= NOFS + 2) ? 1 : 0);
      end else begin
        if (pend) chk("R3/R2/R9 data", dout, expv);
        chk("R3/R10 avail", avail_flag, (model.size() > 0) ? 1 : 0);
        chk("R6 almost_empty", almost_empty, (model.size() >= NOFS + 1) ? 1 : 0);
      end
      if (paused == 0 && model.size() == D + int'(fm) - 1) begin
        rd_en_n = 1; pend = 0; paused = 1;
        repeat (12) @(negedge wr_clk);
        chk("R5 released after first read", space_flag, fm ? 0 : 1);
        continue;
      end
      rd_en_n = 0;
      if (model.size() > 0) begin
        expv = model.pop_front(); pend = 1;
      end else begin
        extras++; pend = 1;
      end
    end
    rd_en_n = 1;
    fall_mode = fm;
  endtask

  initial begin
    do_reset(0);
    fill(0);
    drain(0);
    do_reset(1);
    first_word();
    fill(1);
    drain(1);
    do_reset(0);
    first_word_std();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic first_word_std;
    @(negedge wr_clk); din = val; wr_en_n = 0;
    @(negedge wr_clk); wr_en_n = 1;
    repeat (6) @(negedge rd_clk);
    chk("R3 first word needs read", dout, 0);
    chk("R3 avail", avail_flag, 1);
    rd_en_n = 0;
    @(negedge rd_clk); rd_en_n = 1;
    chk("R3 first word after read", dout, val);
    chk("R3 empty after last", avail_flag, 0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule